// File: doc/BRIEF.md
# Segment Column Capture and Drive-Level Encoder

This block is the digital core of an 80-column dot-matrix LCD segment driver. The controller presents display data one nibble at a time. Each falling edge of a slow shift clock moves one nibble into a first latch. An address counter picks which group of four columns the nibble lands in, and a direction input picks whether the row fills from the high columns down or from the low columns up. After 20 nibbles the row is full, and further shift edges are ignored until the next load.

An active-low enable input gates capture. An active-low enable output falls once this device's row is full, so several devices can be chained: each output feeds the enable input of the next device, and one shared data bus fills a wide panel left to right. A falling edge of the load strobe does three things. It copies the first latch into a second latch, restarts the counter and raises the enable output again. Each of the 80 columns then carries a 2-bit drive-level code. The code depends on the latched bit, the frame-alternation input and a display-off input.

The shift clock and the load strobe are slow external strobes. They are sampled in one fast system clock domain, and a registered falling-edge detector turns each of them into a one-cycle enable.

Top module: `lcd_seg_capture`

## Requirements
- R1: Each accepted falling edge of `shift_clk` writes one `din` nibble into the first latch, and 20 accepted nibbles fill all 80 columns. The write takes effect on the second `clk` rising edge after the first edge that samples `shift_clk` low. `din` is sampled at that first edge.
- R2: With `dir_rev` low, the n-th accepted nibble (n = 0..19) writes `din[k]` (k = 0..3) to column 4·(19−n)+k+1. The first nibble fills columns 77..80 and the last fills columns 1..4.
- R3: With `dir_rev` high, the n-th accepted nibble writes `din[k]` to column 4·n+4−k. The first nibble puts `din[0]..din[3]` into columns 4,3,2,1, and the last puts them into columns 80,79,78,77.
- R4: While `ce_in_n` is high, shift edges write nothing and do not advance the counter.
- R5: A falling edge of `load_stb` copies the first latch into the second latch, and `drive_code` reflects the new row on the same cycle as the copy.
- R6: While `disp_en` is low, every column's code is 00, whatever the data and `alt_m` are.
- R7: While `disp_en` is high, column c's code sits in `drive_code[2c-1:2c-2]` and is chosen by `alt_m` and the latched bit Q. The codes are: `alt_m`=0 with Q=1 gives 00, `alt_m`=0 with Q=0 gives 01, `alt_m`=1 with Q=0 gives 10, and `alt_m`=1 with Q=1 gives 11.
- R8: `ce_out_n` is high while the row is filling. It goes low in the cycle that the 20th nibble is written, and it returns high in the cycle that a load takes effect.
- R9: Shift edges after the 20th accepted nibble are ignored until a load. A load restarts filling at the first group of the selected direction, even if the row was only partly filled.
- R10: While `rst_n` is low at a `clk` edge, both latches and the counter clear and `ce_out_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_clk | input | 1 | Data shift strobe, acts on its falling edge |
| load_stb | input | 1 | Row load strobe, acts on its falling edge |
| din | input | 4 | Display data nibble, din[0] is the first data line |
| dir_rev | input | 1 | Fill direction: 0 fills high columns first, 1 fills low columns first |
| ce_in_n | input | 1 | Active-low capture enable (from the previous device) |
| alt_m | input | 1 | Frame-alternation signal |
| disp_en | input | 1 | Low forces every column to the code 00 |
| ce_out_n | output | 1 | Active-low enable handed to the next device |
| drive_code | output | 160 | Two-bit level code per column; column c occupies bits 2c-1:2c-2 |

## Verification
The assertions assume that `shift_clk` and `load_stb` each stay at a level for at least two `clk` cycles, that `din` and `dir_rev` are steady when a shift edge is sampled, and that both strobes idle high out of reset. The stimulus changes every input only on falling `clk` edges. It holds each strobe level for at least two cycles and never changes `dir_rev` in the middle of a row. Every shift edge is fed to two chained devices, so the enable handoff is exercised, and the stimulus also covers extra nibbles beyond a full chain, nibbles sent while capture is disabled, and a load that arrives partway through a row.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;
  typedef enum logic [1:0] {
    LVL_V1  = 2'b00,
    LVL_V3  = 2'b01,
    LVL_V4  = 2'b10,
    LVL_VEE = 2'b11
  } drive_lvl_e;
endpackage

// File: rtl/lcd_strobe_fall.sv
module lcd_strobe_fall #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] strobe,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  // strobes idle high; registered pulse one cycle wide per falling edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '1;
      fall   <= '0;
    end else begin
      prev_q <= strobe;
      fall   <= prev_q & ~strobe;
    end
  end
endmodule

// File: rtl/lcd_fill_ctrl.sv
module lcd_fill_ctrl #(
  parameter int NGRP = 20,
  parameter int CW   = $clog2(NGRP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load,
  input  logic          ce_in_n,
  output logic [CW-1:0] cnt,
  output logic          accept,
  output logic          ce_out_n
);
  localparam logic [CW-1:0] FULL = CW'(NGRP);
  localparam logic [CW-1:0] LAST = CW'(NGRP - 1);

  assign accept = step & ~ce_in_n & ~load & (cnt != FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      ce_out_n <= 1'b1;
    end else if (load) begin
      cnt      <= '0;
      ce_out_n <= 1'b1;
    end else if (accept) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) ce_out_n <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_col_latch.sv
module lcd_col_latch #(
  parameter int NIB  = 4,
  parameter int NGRP = 20,
  parameter int CW   = $clog2(NGRP + 1),
  parameter int COLS = NIB * NGRP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [CW-1:0]   cnt,
  input  logic            dir_rev,
  input  logic [NIB-1:0]  nib,
  input  logic            xfer,
  output logic [COLS-1:0] lat1,
  output logic [COLS-1:0] lat2
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [CW-1:0] SLOT_UP = CW'(g);
    localparam logic [CW-1:0] SLOT_DN = CW'(NGRP - 1 - g);
    logic hit;
    assign hit = we & (dir_rev ? (cnt == SLOT_UP) : (cnt == SLOT_DN));

    for (genvar j = 0; j < NIB; j++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)   lat1[g*NIB+j] <= 1'b0;
        else if (hit) lat1[g*NIB+j] <= dir_rev ? nib[NIB-1-j] : nib[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    lat2 <= '0;
    else if (xfer) lat2 <= lat1;
  end
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_seg_pkg::*;
#(
  parameter int COLS = 80
) (
  input  logic [COLS-1:0]   q,
  input  logic              alt_m,
  input  logic              disp_en,
  output logic [2*COLS-1:0] code
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    drive_lvl_e lvl;
    always_comb begin
      if (!disp_en) lvl = LVL_V1;
      else begin
        unique case ({alt_m, q[c]})
          2'b00:   lvl = LVL_V3;
          2'b01:   lvl = LVL_V1;
          2'b10:   lvl = LVL_V4;
          default: lvl = LVL_VEE;
        endcase
      end
    end
    assign code[2*c +: 2] = lvl;
  end
endmodule

// File: rtl/lcd_seg_capture.sv
module lcd_seg_capture #(
  parameter int NIB  = 4,
  parameter int NGRP = 20,
  localparam int COLS = NIB * NGRP,
  localparam int CW   = $clog2(NGRP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_clk,
  input  logic              load_stb,
  input  logic [NIB-1:0]    din,
  input  logic              dir_rev,
  input  logic              ce_in_n,
  input  logic              alt_m,
  input  logic              disp_en,
  output logic              ce_out_n,
  output logic [2*COLS-1:0] drive_code
);
  logic [1:0]      falls;
  logic            sh_fall;
  logic            ld_fall;
  logic [NIB-1:0]  din_q;
  logic [CW-1:0]   fill_cnt;
  logic            accept;
  logic [COLS-1:0] lat1;
  logic [COLS-1:0] lat2;

  lcd_strobe_fall #(.W(2)) u_fall (
    .clk(clk), .rst_n(rst_n),
    .strobe({load_stb, shift_clk}),
    .fall(falls)
  );
  assign sh_fall = falls[0];
  assign ld_fall = falls[1];

  // nibble sampled alongside the shift strobe, aligned with sh_fall
  always_ff @(posedge clk) begin
    if (!rst_n) din_q <= '0;
    else        din_q <= din;
  end

  lcd_fill_ctrl #(.NGRP(NGRP), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .step(sh_fall), .load(ld_fall), .ce_in_n(ce_in_n),
    .cnt(fill_cnt), .accept(accept), .ce_out_n(ce_out_n)
  );

  lcd_col_latch #(.NIB(NIB), .NGRP(NGRP), .CW(CW), .COLS(COLS)) u_lat (
    .clk(clk), .rst_n(rst_n),
    .we(accept), .cnt(fill_cnt), .dir_rev(dir_rev), .nib(din_q),
    .xfer(ld_fall), .lat1(lat1), .lat2(lat2)
  );

  lcd_level_enc #(.COLS(COLS)) u_enc (
    .q(lat2), .alt_m(alt_m), .disp_en(disp_en), .code(drive_code)
  );
endmodule

// File: rtl/lcd_seg_capture_chk.sv
module lcd_seg_capture_chk #(
  parameter int COLS = 80,
  parameter int NGRP = 20,
  parameter int CW   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_in_n,
  input logic              disp_en,
  input logic              ce_out_n,
  input logic [2*COLS-1:0] drive_code,
  input logic              sh_fall,
  input logic              ld_fall,
  input logic [CW-1:0]     fill_cnt,
  input logic [COLS-1:0]   lat1,
  input logic [COLS-1:0]   lat2
);
  a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_fall && ce_in_n && !ld_fall) |=> $stable(fill_cnt) && $stable(lat1));

  a_r5_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall |=> lat2 == $past(lat1));

  a_r5_lat2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_fall |=> $stable(lat2));

  a_r6_off_is_v1: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> drive_code == '0);

  a_r8_release_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall |=> ce_out_n && fill_cnt == '0);

  a_r8_low_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_out_n |-> fill_cnt == CW'(NGRP));

  a_r9_full_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == CW'(NGRP) && !ld_fall) |=> $stable(lat1) && fill_cnt == CW'(NGRP));

  a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(NGRP));
endmodule

bind lcd_seg_capture lcd_seg_capture_chk #(.COLS(COLS), .NGRP(NGRP), .CW(CW)) u_chk (.*);

// File: tb/lcd_seg_capture_tb.sv
module lcd_seg_capture_tb;
  localparam int CLK_P = 10;
  localparam int NC    = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_clk = 1'b1, load_stb = 1'b1;
  logic [3:0] din = '0;
  logic dir_rev = 1'b0, ce0_n = 1'b0, alt_m = 1'b0, disp_en = 1'b1;
  logic ceo1_n, ceo2_n;
  logic [2*NC-1:0] code1, code2;
  logic armed = 1'b0;

  int checks = 0, fails = 0, cycles = 0;

  logic [NC-1:0] mq [2];
  logic [NC-1:0] mp [2];
  int            mcnt [2];
  logic          mceo [2];

  always #(CLK_P/2) clk = ~clk;

  lcd_seg_capture u_dut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .load_stb(load_stb),
    .din(din), .dir_rev(dir_rev), .ce_in_n(ce0_n), .alt_m(alt_m),
    .disp_en(disp_en), .ce_out_n(ceo1_n), .drive_code(code1)
  );

  lcd_seg_capture u_dut2 (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .load_stb(load_stb),
    .din(din), .dir_rev(dir_rev), .ce_in_n(ceo1_n), .alt_m(alt_m),
    .disp_en(disp_en), .ce_out_n(ceo2_n), .drive_code(code2)
  );

  function automatic logic [1:0] lvl(input logic q, input logic m, input logic en);
    if (!en) return 2'b00;
    if (!m)  return q ? 2'b00 : 2'b01;
    return q ? 2'b11 : 2'b10;
  endfunction

  function automatic logic [2*NC-1:0] exp_codes(input logic [NC-1:0] q);
    logic [2*NC-1:0] r;
    for (int c = 0; c < NC; c++) r[2*c +: 2] = lvl(q[c], alt_m, disp_en);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      mq[i] = '0; mp[i] = '0; mcnt[i] = 0; mceo[i] = 1'b1;
    end
  endtask

  task automatic model_place(input int i, input logic [3:0] d);
    for (int k = 0; k < 4; k++) begin
      int col;
      col = dir_rev ? 4*mcnt[i] + 4 - k : 4*(19 - mcnt[i]) + k + 1;
      mq[i][col-1] = d[k];
    end
    mcnt[i]++;
    if (mcnt[i] == 20) mceo[i] = 1'b0;
  endtask

  task automatic model_nib(input logic [3:0] d);
    logic a1, a2;
    a1 = !ce0_n && mcnt[0] < 20;
    a2 = !mceo[0] && mcnt[1] < 20;
    if (a1) model_place(0, d);
    if (a2) model_place(1, d);
  endtask

  task automatic model_load();
    for (int i = 0; i < 2; i++) begin
      mp[i] = mq[i]; mcnt[i] = 0; mceo[i] = 1'b1;
    end
  endtask

  task automatic shift_nib(input logic [3:0] d);
    @(negedge clk); shift_clk = 1'b0; din = d;
    @(posedge clk); @(posedge clk);
    model_nib(d);
    @(negedge clk); shift_clk = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_load();
    @(negedge clk); load_stb = 1'b0;
    @(posedge clk); @(posedge clk);
    model_load();
    @(negedge clk); load_stb = 1'b1;
    @(negedge clk);
  endtask

  // cycle-by-cycle comparison against the behavioural model
  always @(posedge clk) begin
    #(CLK_P/4);
    if (armed) begin
      checks++;
      if (code1 !== exp_codes(mp[0]) || code2 !== exp_codes(mp[1])) begin
        fails++;
        $display("FAIL R1/R2/R3/R5/R7: codes actual %h_%h expected %h_%h at %0t",
                 code1, code2, exp_codes(mp[0]), exp_codes(mp[1]), $time);
      end
      checks++;
      if (ceo1_n !== mceo[0] || ceo2_n !== mceo[1]) begin
        fails++;
        $display("FAIL R8: ce_out actual %b%b expected %b%b at %0t",
                 ceo1_n, ceo2_n, mceo[0], mceo[1], $time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2*NC-1:0] snap;
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset state, Q=0 everywhere so each column shows 01 with alt_m=0
    chk("R10 ce_out", {30'd0, ceo1_n, ceo2_n}, 32'h3);
    chk("R10 codes", code1[31:0], 32'h5555_5555);
    chk("R10 codes top", code2[159:128], 32'h5555_5555);
    rst_n = 1'b1;
    @(negedge clk);
    armed = 1'b1;

    // frame 1: high columns first, first nibble known
    dir_rev = 1'b0;
    shift_nib(4'b0001);
    for (int n = 1; n < 20; n++) shift_nib(4'($urandom));
    @(negedge clk);
    chk("R8 ce_out low after 20", {31'd0, ceo1_n}, 32'd0);
    chk("R8 chained still filling", {31'd0, ceo2_n}, 32'd1);
    for (int n = 0; n < 20; n++) shift_nib(4'($urandom));
    shift_nib(4'hF); shift_nib(4'hF); // R9: beyond the chain, ignored
    do_load();
    chk("R8 ce_out high after load", {30'd0, ceo1_n, ceo2_n}, 32'h3);
    // R2: column 77 holds din[0]=1 (code 00), column 80 holds 0 (code 01)
    chk("R2 col77", {30'd0, code1[153:152]}, 32'h0);
    chk("R2 col80", {30'd0, code1[159:158]}, 32'h1);
    alt_m = 1'b1;
    @(negedge clk);
    chk("R7 col77 m1 q1", {30'd0, code1[153:152]}, 32'h3);
    chk("R7 col78 m1 q0", {30'd0, code1[155:154]}, 32'h2);
    disp_en = 1'b0;
    @(negedge clk);
    chk("R6 off chip1", {31'd0, code1 == '0}, 32'd1);
    chk("R6 off chip2", {31'd0, code2 == '0}, 32'd1);
    disp_en = 1'b1; alt_m = 1'b0;

    // frame 2: low columns first
    dir_rev = 1'b1;
    shift_nib(4'b0001);
    for (int n = 1; n < 40; n++) shift_nib(4'($urandom));
    do_load();
    chk("R3 col4", {30'd0, code1[7:6]}, 32'h0);
    chk("R3 col1", {30'd0, code1[1:0]}, 32'h1);

    // R4: capture disabled, nothing is written
    snap = code1;
    ce0_n = 1'b1;
    for (int n = 0; n < 5; n++) shift_nib(4'($urandom));
    do_load();
    chk("R4 row unchanged", {31'd0, code1 == snap}, 32'd1);
    chk("R4 ce_out still high", {31'd0, ceo1_n}, 32'd1);
    ce0_n = 1'b0;

    // R9: partial row then load restarts at group 0
    dir_rev = 1'b0;
    for (int n = 0; n < 7; n++) shift_nib(4'($urandom));
    do_load();
    shift_nib(4'b1110);
    do_load();
    chk("R9 restart col77", {30'd0, code1[153:152]}, 32'h1);
    chk("R9 restart col80", {30'd0, code1[159:158]}, 32'h0);

    // randomized frames in both directions and alternation phases
    for (int f = 0; f < 6; f++) begin
      dir_rev = f[0];
      alt_m   = f[1];
      for (int n = 0; n < 40 + (f % 3); n++) shift_nib(4'($urandom));
      do_load();
    end

    // R10: reset mid-row clears everything
    for (int n = 0; n < 3; n++) shift_nib(4'($urandom));
    @(negedge clk); rst_n = 1'b0; armed = 1'b0;
    @(negedge clk); @(negedge clk);
    model_reset();
    alt_m = 1'b0;
    @(negedge clk);
    chk("R10 codes after reset", {31'd0, code1 == {NC{2'b01}}}, 32'd1);
    chk("R10 ce_out after reset", {30'd0, ceo1_n, ceo2_n}, 32'h3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule